// File: doc/BRIEF.md
# Two-Way Instruction Cache Array with Debug Readback

This block holds the tag, valid, replacement and data state of a two-way set-associative instruction cache with 32 sets of 32-byte lines. A lookup port compares an address against both ways of one set in the same cycle. It returns a hit flag, the hitting way and the addressed 32-bit instruction word. A fill port writes a complete eight-word line. An invalidate port drops any line whose tag matches an address, so that code changed in memory is fetched again.

A separate debug path lets software inspect the array directly. The set comes from the debug address. The way comes from a way-select input, and no tag comparison takes part. One clock after the request, a 32-bit debug register is loaded with either the line tag or the upper bits of one instruction word, packed together with the line valid bit and the set replacement bit. A two-state machine sequences the debug capture. In `DBG_IDLE` no capture is pending. A request moves it to `DBG_CAPTURED`, and it stays there for as long as requests keep arriving. A cycle without a request returns it to `DBG_IDLE`. `dbg_done` is high while the machine is in `DBG_CAPTURED`.

Top module: `icd_cache_top`

## Requirements
- R1: Address fields use bit 0 as the most significant bit. Bits 22:26 (`addr[9:5]`) select the set, bits 27:29 (`addr[4:2]`) select the word within the line, and bits 0:21 (`addr[31:10]`) form the 22-bit tag.
- R2: While `lk_req` is high, `lk_hit` is high in the same cycle exactly when a valid line in the addressed set has a matching tag. `lk_way` then gives the hitting way (0 = way A, 1 = way B), and `lk_word` gives the addressed word. `lk_hit` is low when `lk_req` is low.
- R3: A fill writes into way A if way A is invalid, otherwise into way B if way B is invalid, otherwise into the way named by the set replacement bit. It sets the line valid and stores the tag and all eight words. Word i comes from `fill_line[32*i+31:32*i]`.
- R4: The set replacement bit reads 0 when way A is least recently used and 1 when way B is. A lookup hit sets it to the way that did not hit. A fill sets it to the way that was not filled, and a fill takes precedence over a lookup hit in the same set.
- R5: An invalidate clears the valid bit of every line in the addressed set whose tag matches, and leaves the replacement bit unchanged. When an invalidate and a fill arrive in the same cycle, the fill is dropped.
- R6: A debug read takes the set from `dbg_addr[9:5]` and the way from `dbg_way_sel` (0 = A, 1 = B), whatever the tag bits of `dbg_addr` hold.
- R7: With `dbg_tag_sel` = 1 the INFO field holds the line tag. With `dbg_tag_sel` = 0 it holds the upper 22 bits of the word selected by `dbg_addr[4:2]`.
- R8: The debug register places INFO in bits 0:21 (`dbg_data[31:10]`), the line valid bit in bit 27 (`dbg_data[4]`) and the set replacement bit in bit 31 (`dbg_data[0]`). All other bits read as zero.
- R9: The debug register is loaded at the clock edge that samples `dbg_req`, and `dbg_done` is high for the cycle that follows. It is low after any cycle without a request, and `dbg_data` holds its value until the next request.
- R10: A debug read changes neither valid bits nor replacement bits.
- R11: Reset clears every valid bit, every replacement bit, `dbg_data` and `dbg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit |
| lk_word | output | 32 | Addressed instruction word on a hit |
| fill_req | input | 1 | Line fill request |
| fill_addr | input | 32 | Fill address (tag and set) |
| fill_line | input | 256 | Eight words of the line, word 0 lowest |
| inv_req | input | 1 | Invalidate request |
| inv_addr | input | 32 | Invalidate address |
| dbg_req | input | 1 | Debug read request |
| dbg_addr | input | 32 | Debug address (set and word) |
| dbg_way_sel | input | 1 | Debug way select |
| dbg_tag_sel | input | 1 | Debug info select: 1 tag, 0 word |
| dbg_data | output | 32 | Debug register |
| dbg_done | output | 1 | Debug register loaded |

## Verification
A wrong valid or tag bit shows up in the same cycle as a wrong `lk_hit` on a lookup. It also appears one cycle after a debug read of that line, in `dbg_data[4]` or the INFO field. A corrupted replacement bit stays hidden until the next fill in that set puts a line in the wrong way. It is exposed either at once through `dbg_data[0]` on a debug read, or later through a lookup that misses when it should hit. The bench therefore interleaves fills, lookups, invalidates and debug reads on a small tag pool, so that every replacement decision is soon observed.

// File: rtl/icd_pkg.sv
package icd_pkg;

    // Debug capture sequencing
    typedef enum logic {
        DBG_IDLE     = 1'b0,
        DBG_CAPTURED = 1'b1
    } dbg_state_t;

    // Way encoding shared by lookup, fill and debug paths
    localparam logic WAY_A = 1'b0;
    localparam logic WAY_B = 1'b1;

endpackage

// File: rtl/icd_tag_store.sv
module icd_tag_store #(
    parameter int SETS  = 32,
    parameter int TAG_W = 22,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             fill_way,
    input  logic             inv_req,
    input  logic [SET_W-1:0] inv_set,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic [SET_W-1:0] dbg_set,
    input  logic             dbg_way,
    output logic [TAG_W-1:0] dbg_tag,
    output logic             dbg_valid,
    output logic             dbg_lru
);
    import icd_pkg::*;

    logic [1:0]       vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [SETS-1:0]  lru_q;

    logic [1:0] hit_vec;
    logic [1:0] inv_vec;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[lk_set][w]  && (tag_q[lk_set][w]  == lk_tag);
        assign inv_vec[w] = vld_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag);
    end

    assign lk_hit = lk_req && (|hit_vec);
    assign lk_way = hit_vec[0] ? WAY_A : WAY_B;

    always_comb begin
        if (!vld_q[fill_set][0])      fill_way = WAY_A;
        else if (!vld_q[fill_set][1]) fill_way = WAY_B;
        else                          fill_way = lru_q[fill_set];
    end

    // Valid bits: invalidate clears matching ways; fill sets the victim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
        end else begin
            if (inv_req) begin
                for (int w = 0; w < 2; w++)
                    if (inv_vec[w]) vld_q[inv_set][w] <= 1'b0;
            end
            if (fill_en) vld_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
    end

    // Replacement bits: fill assignment comes last and wins on the same set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lk_hit)  lru_q[lk_set]   <= ~lk_way;
            if (fill_en) lru_q[fill_set] <= ~fill_way;
        end
    end

    assign dbg_tag   = tag_q[dbg_set][dbg_way];
    assign dbg_valid = vld_q[dbg_set][dbg_way];
    assign dbg_lru   = lru_q[dbg_set];

    // Delayed copies for the checks below
    logic [SET_W-1:0] fset_d, iset_d;
    logic [TAG_W-1:0] itag_d;
    logic             fway_d;
    always_ff @(posedge clk) begin
        fset_d <= fill_set;
        fway_d <= fill_way;
        iset_d <= inv_set;
        itag_d <= inv_tag;
    end

    AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[fset_d][fway_d]);                              // R3
    AST_INV_LEAVES_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> !(vld_q[iset_d][0] && tag_q[iset_d][0] == itag_d)
                 && !(vld_q[iset_d][1] && tag_q[iset_d][1] == itag_d)); // R5
    AST_LRU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_hit && !fill_en) |=> $stable(lru_q));                      // R10
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_req);                                             // R2

endmodule

// File: rtl/icd_data_store.sv
module icd_data_store #(
    parameter int SETS   = 32,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              ra_way,
    input  logic [SET_W-1:0]  ra_set,
    input  logic [OFF_W-1:0]  ra_off,
    output logic [WORD_W-1:0] ra_word,
    input  logic              rb_way,
    input  logic [SET_W-1:0]  rb_set,
    input  logic [OFF_W-1:0]  rb_off,
    output logic [WORD_W-1:0] rb_word
);
    logic [WORD_W-1:0] mem_q [2][SETS][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < WORDS; i++)
                mem_q[wr_way][wr_set][i] <= wr_line[i*WORD_W +: WORD_W];
        end
    end

    assign ra_word = mem_q[ra_way][ra_set][ra_off];
    assign rb_word = mem_q[rb_way][rb_set][rb_off];

endmodule

// File: rtl/icd_dbg_fsm.sv
module icd_dbg_fsm #(
    parameter int TAG_W  = 22,
    parameter int WORD_W = 32,
    parameter int DBG_W  = 32,
    parameter int V_BIT  = 27,
    parameter int L_BIT  = 31,
    localparam int V_POS = DBG_W - 1 - V_BIT,
    localparam int L_POS = DBG_W - 1 - L_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              tag_sel,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [WORD_W-1:0] line_word,
    input  logic              line_valid,
    input  logic              set_lru,
    output logic [DBG_W-1:0]  dbg_data,
    output logic              dbg_done
);
    import icd_pkg::*;

    dbg_state_t state_q, state_d;
    logic [DBG_W-1:0] packed_w;
    logic [TAG_W-1:0] info;

    always_comb begin
        unique case (state_q)
            DBG_IDLE:     state_d = req ? DBG_CAPTURED : DBG_IDLE;
            DBG_CAPTURED: state_d = req ? DBG_CAPTURED : DBG_IDLE;
            default:      state_d = DBG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DBG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        info     = tag_sel ? line_tag : line_word[WORD_W-1 -: TAG_W];
        packed_w = '0;
        packed_w[DBG_W-1 -: TAG_W] = info;
        packed_w[V_POS] = line_valid;
        packed_w[L_POS] = set_lru;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   dbg_data <= '0;
        else if (req) dbg_data <= packed_w;
    end

    assign dbg_done = (state_q == DBG_CAPTURED);

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> dbg_done);                                              // R9
    AST_NO_DONE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !dbg_done);                                            // R9
    AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(dbg_data));                                    // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_done |-> (dbg_data[V_POS+1 +: DBG_W-TAG_W-V_POS-1] == '0)
                  && (dbg_data[L_POS+1 +: V_POS-L_POS-1] == '0));      // R8

endmodule

// File: rtl/icd_cache_top.sv
module icd_cache_top #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int DBG_W  = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W - BYTE_W,
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_way,
    output logic [WORD_W-1:0] lk_word,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              dbg_req,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_way_sel,
    input  logic              dbg_tag_sel,
    output logic [DBG_W-1:0]  dbg_data,
    output logic              dbg_done
);
    localparam int SET_LO = BYTE_W + OFF_W;

    logic [SET_W-1:0] lk_set, fill_set, inv_set, dbg_set;
    logic [TAG_W-1:0] lk_tag, fill_tag, inv_tag, dbg_tag;
    logic [OFF_W-1:0] lk_off, dbg_off;
    logic             fill_en, fill_way, dbg_valid, dbg_lru;
    logic [WORD_W-1:0] dbg_word;

    assign lk_set   = lk_addr[SET_LO +: SET_W];
    assign fill_set = fill_addr[SET_LO +: SET_W];
    assign inv_set  = inv_addr[SET_LO +: SET_W];
    assign dbg_set  = dbg_addr[SET_LO +: SET_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign inv_tag  = inv_addr[ADDR_W-1 -: TAG_W];
    assign lk_off   = lk_addr[BYTE_W +: OFF_W];
    assign dbg_off  = dbg_addr[BYTE_W +: OFF_W];

    // Invalidate wins over a same-cycle fill
    assign fill_en = fill_req && !inv_req;

    icd_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .fill_en   (fill_en),
        .fill_set  (fill_set),
        .fill_tag  (fill_tag),
        .fill_way  (fill_way),
        .inv_req   (inv_req),
        .inv_set   (inv_set),
        .inv_tag   (inv_tag),
        .dbg_set   (dbg_set),
        .dbg_way   (dbg_way_sel),
        .dbg_tag   (dbg_tag),
        .dbg_valid (dbg_valid),
        .dbg_lru   (dbg_lru)
    );

    icd_data_store #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_way  (fill_way),
        .wr_set  (fill_set),
        .wr_line (fill_line),
        .ra_way  (lk_way),
        .ra_set  (lk_set),
        .ra_off  (lk_off),
        .ra_word (lk_word),
        .rb_way  (dbg_way_sel),
        .rb_set  (dbg_set),
        .rb_off  (dbg_off),
        .rb_word (dbg_word)
    );

    icd_dbg_fsm #(.TAG_W(TAG_W), .WORD_W(WORD_W), .DBG_W(DBG_W)) u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (dbg_req),
        .tag_sel    (dbg_tag_sel),
        .line_tag   (dbg_tag),
        .line_word  (dbg_word),
        .line_valid (dbg_valid),
        .set_lru    (dbg_lru),
        .dbg_data   (dbg_data),
        .dbg_done   (dbg_done)
    );

endmodule

// File: tb/tb_icd_cache_top.sv
module tb_icd_cache_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic         lk_req = 0, fill_req = 0, inv_req = 0, dbg_req = 0;
    logic [31:0]  lk_addr = 0, fill_addr = 0, inv_addr = 0, dbg_addr = 0;
    logic [255:0] fill_line = 0;
    logic         dbg_way_sel = 0, dbg_tag_sel = 0;
    logic         lk_hit, lk_way, dbg_done;
    logic [31:0]  lk_word, dbg_data;

    icd_cache_top dut (.*);

    int checks = 0, errors = 0;

    // Behavioural reference state
    bit          mv [2][32];
    bit          mw [2][32];
    logic [21:0] mt [2][32];
    logic [31:0] md [2][32][8];
    bit          ml [32];
    bit          exp_done = 0;
    logic [31:0] exp_dbg = 0;
    string       exp_tag = "R9";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input logic [21:0] t, input int s, input int o);
        return {t, s[4:0], o[2:0], 2'b00};
    endfunction

    function automatic logic [255:0] mk_line(input int seed);
        logic [255:0] l;
        for (int i = 0; i < 8; i++)
            l[i*32 +: 32] = (seed * 32'h0101_0101) ^ (i * 32'h1040_0400) ^ 32'h5A00_0000;
        return l;
    endfunction

    // One clock: drive at negedge, compare, advance the model
    task automatic cyc(input bit lk, input logic [31:0] la,
                       input bit fl, input logic [31:0] fa, input logic [255:0] fd,
                       input bit iv, input logic [31:0] ia,
                       input bit dr, input logic [31:0] da, input bit ws, input bit ts,
                       input string lt, input string dt);
        int s, o, hw, vw;
        bit hit;
        logic [21:0] t, info;
        lk_req = lk; lk_addr = la; fill_req = fl; fill_addr = fa; fill_line = fd;
        inv_req = iv; inv_addr = ia; dbg_req = dr; dbg_addr = da;
        dbg_way_sel = ws; dbg_tag_sel = ts;
        #1;
        chk(dbg_done == exp_done, "R9", "dbg_done", 32'(dbg_done), 32'(exp_done));
        if (exp_done) chk(dbg_data == exp_dbg, exp_tag, "dbg_data", dbg_data, exp_dbg);
        s = int'(la[9:5]); o = int'(la[4:2]); t = la[31:10];
        hit = 0; hw = 0;
        for (int w = 1; w >= 0; w--) if (mv[w][s] && mt[w][s] == t) begin hit = 1; hw = w; end
        hit = hit && lk;
        chk(lk_hit == hit, lt, "lk_hit", 32'(lk_hit), 32'(hit));
        if (hit) begin
            chk(lk_way == hw[0], lt, "lk_way", 32'(lk_way), hw);
            chk(lk_word == md[hw][s][o], lt, "lk_word", lk_word, md[hw][s][o]);
        end
        // debug expectation from pre-edge state
        exp_done = dr;
        if (dr) begin
            int ds = int'(da[9:5]);
            info = ts ? mt[ws][ds] : md[ws][ds][da[4:2]][31:10];
            exp_dbg = {info, 5'b0, mv[ws][ds], 3'b0, ml[ds]};
            exp_tag = dt;
        end
        // victim from pre-edge state
        begin
            int fs = int'(fa[9:5]);
            vw = !mv[0][fs] ? 0 : (!mv[1][fs] ? 1 : int'(ml[fs]));
            if (hit) ml[s] = ~hw[0];
            if (iv) begin
                int is = int'(ia[9:5]);
                for (int w = 0; w < 2; w++)
                    if (mv[w][is] && mt[w][is] == ia[31:10]) mv[w][is] = 0;
            end
            if (fl && !iv) begin
                mv[vw][fs] = 1; mw[vw][fs] = 1; mt[vw][fs] = fa[31:10];
                for (int i = 0; i < 8; i++) md[vw][fs][i] = fd[i*32 +: 32];
                ml[fs] = ~vw[0];
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2", "R9");
    endtask
    task automatic look(input logic [31:0] a, input string tag);
        cyc(1, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag, "R9");
    endtask
    task automatic fill(input logic [31:0] a, input int seed);
        cyc(0, 0, 1, a, mk_line(seed), 0, 0, 0, 0, 0, 0, "R2", "R9");
    endtask
    task automatic dread(input logic [31:0] a, input bit ws, input bit ts, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, a, ws, ts, "R2", tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [21:0] tx, ty, tz;
        tx = 22'h12345; ty = 22'h2ABCD; tz = 22'h00F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state at the ports
        chk(dbg_done == 0, "R11", "dbg_done after reset", 32'(dbg_done), 0);
        chk(dbg_data == 0, "R11", "dbg_data after reset", dbg_data, 0);
        dread(mk_addr(0, 3, 0), 0, 1, "R11");
        dread(mk_addr(0, 3, 0), 1, 1, "R11");
        look(mk_addr(tx, 5, 0), "R11");
        // R3: first fill to way A, second to way B
        fill(mk_addr(tx, 5, 0), 1);
        fill(mk_addr(ty, 5, 0), 2);
        dread(mk_addr(0, 5, 0), 0, 1, "R3");
        dread(mk_addr(0, 5, 0), 1, 1, "R3");
        // R2/R1: lookups by word position
        for (int o = 0; o < 8; o++) look(mk_addr(tx, 5, o), "R1");
        look(mk_addr(ty, 5, 7), "R2");
        look(mk_addr(ty, 6, 7), "R1");
        // R4: hit on A leaves B least recently used
        look(mk_addr(tx, 5, 2), "R4");
        dread(mk_addr(0, 5, 0), 0, 1, "R4");
        fill(mk_addr(tz, 5, 0), 3);
        look(mk_addr(ty, 5, 0), "R4");
        look(mk_addr(tx, 5, 0), "R4");
        look(mk_addr(tz, 5, 3), "R4");
        // R6/R7/R8: forced way, tag and word info, unrelated tag bits
        dread(mk_addr(22'h3FFFF, 5, 0), 0, 1, "R6");
        dread(mk_addr(22'h11111, 5, 4), 1, 0, "R7");
        dread(mk_addr(0, 5, 7), 0, 0, "R7");
        dread(mk_addr(0, 5, 1), 1, 1, "R8");
        // R9: back-to-back requests, then hold
        dread(mk_addr(0, 5, 0), 0, 1, "R9");
        dread(mk_addr(0, 5, 3), 1, 0, "R9");
        idle();
        chk(dbg_data == exp_dbg, "R9", "dbg_data hold", dbg_data, exp_dbg);
        idle();
        // R10: debug reads do not move replacement state
        for (int k = 0; k < 4; k++) dread(mk_addr(0, 5, k), k[0], 1, "R10");
        fill(mk_addr(22'h0AAAA, 5, 0), 4);
        dread(mk_addr(0, 5, 0), 0, 1, "R10");
        dread(mk_addr(0, 5, 0), 1, 1, "R10");
        // R5: invalidate, and invalidate beating a fill
        cyc(0, 0, 0, 0, 0, 1, mk_addr(22'h0AAAA, 5, 0), 0, 0, 0, 0, "R5", "R5");
        look(mk_addr(22'h0AAAA, 5, 0), "R5");
        cyc(0, 0, 1, mk_addr(tx, 9, 0), mk_line(7), 1, mk_addr(tx, 9, 0), 0, 0, 0, 0, "R5", "R5");
        look(mk_addr(tx, 9, 0), "R5");
        dread(mk_addr(0, 5, 0), 0, 1, "R5");
        dread(mk_addr(0, 5, 0), 1, 1, "R5");
        // Mixed traffic on a small tag pool
        for (int n = 0; n < 600; n++) begin
            logic [21:0] t1, t2, t3;
            int s1, s2, s3, s4;
            bit dts, dws;
            t1 = 22'(32'h100 + $urandom_range(0, 3));
            t2 = 22'(32'h100 + $urandom_range(0, 3));
            t3 = 22'(32'h100 + $urandom_range(0, 3));
            s1 = $urandom_range(0, 3); s2 = $urandom_range(0, 3);
            s3 = $urandom_range(0, 3); s4 = $urandom_range(0, 3);
            dws = 1'($urandom_range(0, 1));
            dts = 1'($urandom_range(0, 1));
            if (!mw[dws][s4]) dts = 1;
            cyc(1'($urandom_range(0, 1)), mk_addr(t1, s1, $urandom_range(0, 7)),
                ($urandom_range(0, 2) == 0), mk_addr(t2, s2, 0), mk_line(n + 10),
                ($urandom_range(0, 5) == 0), mk_addr(t3, s3, 0),
                1'($urandom_range(0, 1)), mk_addr(22'h3FF, s4, $urandom_range(0, 7)),
                dws, dts, "R2", "R8");
        end
        idle();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule